// File: doc/BRIEF.md
# Instruction Cycle Bus Controller

This block is the control sequencer of a small accumulator machine. It works through each instruction in fixed phases: it places the program counter in the memory address register, it reads the instruction word into the buffer register, and in a later cycle it copies that word into the instruction register. It then decodes the word and, when the instruction needs one, it runs an operand transfer on the shared bus. After the work of the instruction is done, it always spends one cycle testing for an interrupt.

The bus carries three strobes. The space select chooses memory (1) or I/O (0). The direction strobe marks a write (1) or a read (0). The output enable asks the addressed memory or device to drive the read data. Memory and I/O each have their own address register. The accumulator is the only working register, and a second register B can exchange values with it. The program counter steps through a dedicated incrementer.

Interrupts are accepted only at the test cycle and only when the request, the global enable input and an internal mask flag are all high. On entry the controller saves the program counter, closes the mask and jumps to a fixed handler address. A return instruction reverses all three steps, so handlers never nest.

Top module: `icyc_ctrl`

## Requirements
- R1: An instruction word is bits [15:12] opcode and [11:0] operand. Each instruction begins with one idle cycle, then a fetch cycle with space=1, dir=0, oe=1 and the address equal to the program counter, then two idle cycles, one to load the instruction register and one to decode.
- R2: The program counter increases by exactly one per fetch, so straight-line code is fetched from consecutive addresses.
- R3: Opcode 2 (load) runs one idle cycle, then a read with space=1, dir=0, oe=1 at the operand address, then an idle cycle. After that the accumulator holds the word that was read.
- R4: Opcode 3 (store) runs one idle cycle, then a write cycle with space=1, dir=1, oe=0 at the operand address, with the write data equal to the accumulator.
- R5: Opcode 4 (input) reads the I/O space with space=0, dir=0, oe=1 and loads the accumulator. Opcode 5 (output) writes the accumulator to the I/O space with space=0, dir=1, oe=0. Both use the I/O address register, loaded from the operand field.
- R6: Every cycle that is not a fetch or an operand transfer has dir=0 and oe=0. Dir and oe are never high together.
- R7: Opcode 1 (branch) loads the program counter from the operand field, so the next fetch is at the operand address.
- R8: Opcode 6 copies the accumulator into B and opcode 7 copies B into the accumulator. Neither uses the bus.
- R9: In the test cycle that ends every instruction, if irq, irq_en and the mask flag are all high, the program counter is saved, the mask flag closes, and the next fetch is at HANDLER_ADDR. If irq_en is low, the interrupt is not taken.
- R10: Opcode 8 (return) restores the saved program counter and reopens the mask. The test cycle of that same return instruction already sees the mask open. While the mask is closed, a request is not taken.
- R11: Opcodes 0 and 9 to 15 do nothing. After decode they spend one idle cycle and then go to the interrupt test.
- R12: While rst_n is low at a clock edge, the controller returns to its first fetch phase with the program counter at RESET_PC and the mask open. During reset, dir and oe stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| irq_en | input | 1 | Global interrupt enable |
| bus_rdata | input | WORD_W | Read data from memory or I/O |
| bus_wdata | output | WORD_W | Write data (buffer register) |
| bus_addr | output | ADR_W | Memory or I/O address |
| bus_iom | output | 1 | Space select: 1 memory, 0 I/O |
| bus_rw | output | 1 | Direction: 1 write, 0 read |
| bus_oe | output | 1 | Output enable for read data |

## Verification
The hardest case to reach is a return instruction while the request is still high. In that case the mask reopens in the execute cycle, and the test cycle one clock later takes the interrupt again at once. The saved address must still be the one stored on the first entry. To reach it, the stimulus holds irq high across two whole handler runs and drops it only partway through the second run. Earlier in the program, irq is held high with irq_en low for several instructions, which shows that the global enable blocks entry. The bench model decides every entry and return at instruction level and predicts the bus activity of every cycle.

// File: rtl/icyc_pkg.sv
// Shared phase encoding and opcode helpers for the instruction cycle controller.
// Assumes a 4-bit opcode in the top bits of the instruction word.
package icyc_pkg;

    typedef enum logic [3:0] {
        PH_F_ADDR  = 4'd0,
        PH_F_READ  = 4'd1,
        PH_F_LOAD  = 4'd2,
        PH_DECODE  = 4'd3,
        PH_O_ADDR  = 4'd4,
        PH_O_READ  = 4'd5,
        PH_EXEC    = 4'd6,
        PH_O_STORE = 4'd7,
        PH_INT     = 4'd8
    } phase_e;

    localparam logic [3:0] OP_BR  = 4'd1;
    localparam logic [3:0] OP_LD  = 4'd2;
    localparam logic [3:0] OP_ST  = 4'd3;
    localparam logic [3:0] OP_IN  = 4'd4;
    localparam logic [3:0] OP_OUT = 4'd5;
    localparam logic [3:0] OP_MVA = 4'd6;
    localparam logic [3:0] OP_MVB = 4'd7;
    localparam logic [3:0] OP_RET = 4'd8;

    // True for opcodes that address the I/O space
    function automatic logic op_is_io(input logic [3:0] op);
        return (op == OP_IN) || (op == OP_OUT);
    endfunction

    // True for opcodes that write to the bus
    function automatic logic op_is_store(input logic [3:0] op);
        return (op == OP_ST) || (op == OP_OUT);
    endfunction

    // True for opcodes that move an operand over the bus
    function automatic logic op_is_xfer(input logic [3:0] op);
        return (op == OP_LD) || (op == OP_ST) || (op == OP_IN) || (op == OP_OUT);
    endfunction

endpackage

// File: rtl/icyc_seq.sv
// Phase sequencer: steps through the fetch, decode, operand and interrupt-test phases.
// Assumes the opcode input is stable from the decode phase onwards.
module icyc_seq
    import icyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] opc,
    output phase_e     phase
);

    phase_e nxt;

    // Phase register with synchronous reset to the first fetch phase
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_F_ADDR;
        else        phase <= nxt;
    end

    // Next-phase selection from the current phase and the decoded opcode
    always_comb begin
        nxt = PH_F_ADDR;
        unique case (phase)
            PH_F_ADDR:  nxt = PH_F_READ;
            PH_F_READ:  nxt = PH_F_LOAD;
            PH_F_LOAD:  nxt = PH_DECODE;
            PH_DECODE:  nxt = op_is_xfer(opc) ? PH_O_ADDR : PH_EXEC;
            PH_O_ADDR:  nxt = op_is_store(opc) ? PH_O_STORE : PH_O_READ;
            PH_O_READ:  nxt = PH_EXEC;
            PH_EXEC:    nxt = PH_INT;
            PH_O_STORE: nxt = PH_INT;
            PH_INT:     nxt = PH_F_ADDR;
            default:    nxt = PH_F_ADDR;
        endcase
    end

    // R1: a fetch read is always preceded by the address-load phase
    a_r1_addr_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_F_READ) |-> ($past(phase) == PH_F_ADDR));

endmodule

// File: rtl/icyc_strobe.sv
// Bus strobe encoder: turns the phase and opcode into space, direction and output enable.
// Assumes idle cycles keep the space select at memory, with dir and oe low.
module icyc_strobe
    import icyc_pkg::*;
(
    input  phase_e     phase,
    input  logic [3:0] opc,
    output logic       iom,
    output logic       rw,
    output logic       oe,
    output logic       use_ioar
);

    // Strobe encoding for each phase
    always_comb begin
        iom      = 1'b1;
        rw       = 1'b0;
        oe       = 1'b0;
        use_ioar = 1'b0;
        case (phase)
            PH_F_READ: oe = 1'b1;
            PH_O_READ: begin
                oe       = 1'b1;
                iom      = !op_is_io(opc);
                use_ioar = op_is_io(opc);
            end
            PH_O_STORE: begin
                rw       = 1'b1;
                iom      = !op_is_io(opc);
                use_ioar = op_is_io(opc);
            end
            default: ;
        endcase
    end

    // Checks on the strobe combinations
    always_comb begin
        a_r6_no_read_and_write: assert (!(rw && oe));
        a_r5_io_space_only_io_ops: assert (iom || op_is_io(opc));
    end

endmodule

// File: rtl/icyc_dpath.sv
// Register datapath: PC, MAR, MBR, IR, I/O address, accumulator, B, saved PC and mask flag.
// Assumes the bus read data is valid in the phases where oe is high.
module icyc_dpath
    import icyc_pkg::*;
#(
    parameter int ADR_W = 12,
    parameter int WORD_W = 16,
    parameter logic [ADR_W-1:0] HANDLER_ADDR = '0,
    parameter logic [ADR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              irq_req,
    input  logic              use_ioar,
    input  logic [WORD_W-1:0] rdata,
    output logic [3:0]        opc,
    output logic [ADR_W-1:0]  addr,
    output logic [WORD_W-1:0] wdata
);

    localparam int OPC_LSB = WORD_W - 4;

    logic [ADR_W-1:0]  pc, mar, ioar, saved;
    logic [WORD_W-1:0] mbr, ir, acc, breg;
    logic              ien;
    logic              take;
    logic [ADR_W-1:0]  operand;

    assign opc     = ir[WORD_W-1:OPC_LSB];
    assign operand = ir[ADR_W-1:0];
    assign take    = (phase == PH_INT) && irq_req && ien;
    assign addr    = use_ioar ? ioar : mar;
    assign wdata   = mbr;

    // Program counter, saved context and interrupt mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            saved <= '0;
            ien   <= 1'b1;
        end else if (phase == PH_F_READ) begin
            pc <= pc + 1'b1;
        end else if (phase == PH_EXEC && opc == OP_BR) begin
            pc <= operand;
        end else if (phase == PH_EXEC && opc == OP_RET) begin
            pc  <= saved;
            ien <= 1'b1;
        end else if (take) begin
            saved <= pc;
            pc    <= HANDLER_ADDR;
            ien   <= 1'b0;
        end
    end

    // Bus-side registers and the working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar  <= '0;
            ioar <= '0;
            mbr  <= '0;
            ir   <= '0;
            acc  <= '0;
            breg <= '0;
        end else begin
            case (phase)
                PH_F_ADDR: mar <= pc;
                PH_F_READ: mbr <= rdata;
                PH_F_LOAD: ir  <= mbr;
                PH_O_ADDR: begin
                    if (op_is_io(opc)) ioar <= operand;
                    else               mar  <= operand;
                    if (op_is_store(opc)) mbr <= acc;
                end
                PH_O_READ: mbr <= rdata;
                PH_EXEC: begin
                    if (opc == OP_LD || opc == OP_IN) acc  <= mbr;
                    if (opc == OP_MVA)                breg <= acc;
                    if (opc == OP_MVB)                acc  <= breg;
                end
                default: ;
            endcase
        end
    end

    // R2: one increment per fetch
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_F_LOAD) |-> (pc == ADR_W'($past(pc) + 1'b1)));

    // R1: IR takes the buffer value one cycle after capture
    a_r1_ir_from_mbr: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |-> (ir == $past(mbr)));

    // R7: branch target comes from the operand field
    a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT && $past(phase) == PH_EXEC && $past(opc) == OP_BR)
        |-> (pc == $past(operand)));

    // R9: entry closes the mask and goes to the handler
    a_r9_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> (!ien && pc == HANDLER_ADDR));

    // R10: return restores the context and reopens the mask
    a_r10_return_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT && $past(phase) == PH_EXEC && $past(opc) == OP_RET)
        |-> (ien && pc == $past(saved)));

endmodule

// File: rtl/icyc_ctrl.sv
// Instruction cycle bus controller top: sequencer, strobe encoder and datapath.
// Assumes the external bus returns read data combinationally while oe is high.
module icyc_ctrl
    import icyc_pkg::*;
#(
    parameter int ADR_W = 12,
    parameter int WORD_W = 16,
    parameter logic [ADR_W-1:0] HANDLER_ADDR = 12'h100,
    parameter logic [ADR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              irq_en,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [ADR_W-1:0]  bus_addr,
    output logic              bus_iom,
    output logic              bus_rw,
    output logic              bus_oe
);

    phase_e     phase;
    logic [3:0] opc;
    logic       use_ioar;

    icyc_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .opc   (opc),
        .phase (phase)
    );

    icyc_strobe u_strobe (
        .phase    (phase),
        .opc      (opc),
        .iom      (bus_iom),
        .rw       (bus_rw),
        .oe       (bus_oe),
        .use_ioar (use_ioar)
    );

    icyc_dpath #(
        .ADR_W        (ADR_W),
        .WORD_W       (WORD_W),
        .HANDLER_ADDR (HANDLER_ADDR),
        .RESET_PC     (RESET_PC)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .irq_req  (irq && irq_en),
        .use_ioar (use_ioar),
        .rdata    (bus_rdata),
        .opc      (opc),
        .addr     (bus_addr),
        .wdata    (bus_wdata)
    );

    // R12: the bus stays quiet during reset
    a_r12_reset_quiet: assert property (@(posedge clk)
        (!rst_n) |-> (!bus_rw && !bus_oe));

endmodule

// File: tb/icyc_ctrl_tb.sv
`timescale 1ns/1ps
// Instruction-level reference model that predicts the bus activity of every cycle.
module icyc_ctrl_tb;

    localparam logic [11:0] HANDLER = 12'h200;
    localparam int N_INSTR = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] bus_wdata;
    logic [11:0] bus_addr;
    logic        bus_iom, bus_rw, bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    icyc_ctrl #(.HANDLER_ADDR(HANDLER)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .irq_en(irq_en),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .bus_addr(bus_addr),
        .bus_iom(bus_iom), .bus_rw(bus_rw), .bus_oe(bus_oe)
    );

    logic [15:0] env_mem [4096];
    logic [15:0] mdl_mem [4096];

    function automatic logic [15:0] io_val(input logic [11:0] a);
        return {4'hC, a} ^ 16'h0F0F;
    endfunction

    // Environment: memory and I/O devices answer reads
    always_comb begin
        if (!bus_oe)      bus_rdata = 16'h0000;
        else if (bus_iom) bus_rdata = env_mem[bus_addr];
        else              bus_rdata = io_val(bus_addr);
    end

    typedef struct packed {
        logic        iom;
        logic        rw;
        logic        oe;
        logic [11:0] addr;
        logic [15:0] dat;
        logic [3:0]  tag;
    } exp_t;

    exp_t q[$];

    logic [11:0] m_pc = 12'h000;
    logic [11:0] m_saved = 12'h000;
    logic [15:0] m_acc = 16'h0, m_b = 16'h0;
    bit          m_ien = 1;
    bit          m_moved = 0;
    int          m_fetch_tag = 1;

    function automatic string tag_str(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic push(input logic iom, input logic rw, input logic oe,
                        input logic [11:0] a, input logic [15:0] d, input int t);
        exp_t e;
        e.iom = iom; e.rw = rw; e.oe = oe; e.addr = a; e.dat = d; e.tag = 4'(t);
        q.push_back(e);
    endtask

    task automatic idle(input int t);
        push(1'b1, 1'b0, 1'b0, 12'h0, 16'h0, t);
    endtask

    // Model one whole instruction and queue its per-cycle bus activity
    task automatic gen_instr();
        logic [15:0] w;
        logic [3:0]  op;
        logic [11:0] opd;
        int          nxt_tag;
        w = mdl_mem[m_pc];
        op = w[15:12];
        opd = w[11:0];
        nxt_tag = 2;
        idle(6);
        push(1'b1, 1'b0, 1'b1, m_pc, 16'h0, m_fetch_tag);   // R1 / R2 / R7 / R9 / R10 fetch
        idle(6);
        idle(6);
        m_pc = m_pc + 12'd1;
        case (op)
            4'd2: begin  // R3 load
                idle(6); push(1'b1, 1'b0, 1'b1, opd, 16'h0, 3); idle(6);
                m_acc = mdl_mem[opd]; m_moved = 0;
            end
            4'd3: begin  // R4 store, R8 after a move
                idle(6); push(1'b1, 1'b1, 1'b0, opd, m_acc, m_moved ? 8 : 4);
                mdl_mem[opd] = m_acc;
            end
            4'd4: begin  // R5 input
                idle(6); push(1'b0, 1'b0, 1'b1, opd, 16'h0, 5); idle(6);
                m_acc = io_val(opd); m_moved = 0;
            end
            4'd5: begin  // R5 output
                idle(6); push(1'b0, 1'b1, 1'b0, opd, m_acc, m_moved ? 8 : 5);
            end
            4'd1: begin idle(6); m_pc = opd; nxt_tag = 7; end
            4'd6: begin idle(8); m_b = m_acc; end
            4'd7: begin idle(8); m_acc = m_b; m_moved = 1; end
            4'd8: begin idle(6); m_pc = m_saved; m_ien = 1; nxt_tag = 10; end
            default: idle(11);  // R11 no-operation
        endcase
        idle(6);  // interrupt test cycle
        if (irq && irq_en && m_ien) begin
            m_saved = m_pc; m_pc = HANDLER; m_ien = 0; nxt_tag = 9;
        end
        m_fetch_tag = nxt_tag;
    endtask

    // Compare the current bus cycle against one expectation
    task automatic compare(input exp_t e);
        bit bad;
        bad = (bus_rw !== e.rw) || (bus_oe !== e.oe);
        if ((e.rw || e.oe) && ((bus_iom !== e.iom) || (bus_addr !== e.addr))) bad = 1;
        if (e.rw && (bus_wdata !== e.dat)) bad = 1;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s got iom=%b rw=%b oe=%b addr=%h wdata=%h exp iom=%b rw=%b oe=%b addr=%h wdata=%h",
                     tag_str(int'(e.tag)), bus_iom, bus_rw, bus_oe, bus_addr, bus_wdata,
                     e.iom, e.rw, e.oe, e.addr, e.dat);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        env_mem[a] = d; mdl_mem[a] = d;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin env_mem[i] = 16'h0; mdl_mem[i] = 16'h0; end
        put(12'h000, 16'h2040); put(12'h001, 16'h3041); put(12'h002, 16'h4005);
        put(12'h003, 16'h500A); put(12'h004, 16'h6000); put(12'h005, 16'h2042);
        put(12'h006, 16'h5003); put(12'h007, 16'h7000); put(12'h008, 16'h3043);
        put(12'h009, 16'h1020); put(12'h00A, 16'h5EEE);
        put(12'h020, 16'hF000); put(12'h021, 16'h2041); put(12'h022, 16'h5007);
        put(12'h023, 16'h1021);
        put(12'h040, 16'h1234); put(12'h042, 16'hBEEF);
        put(HANDLER, 16'h50FF); put(HANDLER + 12'd1, 16'h4011);
        put(HANDLER + 12'd2, 16'h5012); put(HANDLER + 12'd3, 16'h8000);

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R12: quiet bus during reset
        checks++;
        if (bus_rw !== 1'b0 || bus_oe !== 1'b0) begin
            errors++;
            $display("FAIL R12 got rw=%b oe=%b exp rw=0 oe=0", bus_rw, bus_oe);
        end
        rst_n = 1'b1;

        for (int n = 0; n < N_INSTR; n++) begin
            // Request schedule: R9 blocked by irq_en, then taken, R10 re-entry after return
            if (n < 6)       begin irq = 1'b0; irq_en = 1'b1; end
            else if (n < 10) begin irq = 1'b1; irq_en = 1'b0; end
            else if (n < 16) begin irq = 1'b1; irq_en = 1'b1; end
            else             begin irq = 1'b0; irq_en = 1'b1; end
            gen_instr();
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e);
                if (bus_rw === 1'b1 && bus_iom === 1'b1) env_mem[bus_addr] = bus_wdata;
                @(negedge clk);
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule